// File: doc/BRIEF.md
# Speculative Thread Dependence Buffer

This block sits in every thread unit of a ring of speculative thread processors. It keeps a small fully associative table of memory addresses that the predecessor thread has said it may store to. The predecessor sends three kinds of events over an upstream link. A declaration creates a pending entry. A store fills the entry with a value. A release marks the entry as not to be written.

Local loads look up this table in the same cycle. A load to a pending address stalls. A load to an address with forwarded data returns that data. A load to a released or unknown address is told to go to the data cache.

The local thread's own declarations, stores and releases are not kept in the table. They go out on the downstream link, one registered lane per local port, and a lane holds its event while the successor pushes back. One flush input handles both an abort and the end of write-back: it clears the table and the downstream lanes in a single cycle.

Top module: `tsdep_buffer`

## Requirements
- R1: After reset the table is empty, so every local load reports a cache miss. No downstream lane is valid and no upstream retry is raised.
- R2: An upstream declaration (op code 2'b00) for an address makes a pending entry. From the next cycle, a local load (op code 2'b11) to that address raises the port's stall and neither its forward nor its miss output.
- R3: An upstream store (op code 2'b01) gives its address the stored value. From the next cycle, a local load to that address raises forward and returns the value on the port's data output. The data output is zero whenever forward is low, and stall, forward and miss are never raised together.
- R4: An upstream release (op code 2'b10) of a declared address makes later local loads to it miss. A release of an address that is not in the table is accepted and changes nothing.
- R5: A local load to an address that is not in the table reports a miss.
- R6: When all entries are in use, an upstream declaration or store to a new address raises that lane's retry in the same cycle and is not recorded. An event that hits an existing entry is still accepted.
- R7: A local declaration, store or release that is accepted on port p appears one cycle later on downstream lane p, with the same op code, address and data. A local load is never sent downstream.
- R8: While downstream lane p is valid and its retry input is high, the lane keeps its event unchanged, and any local non-load request on port p is stalled.
- R9: When two local ports present the same address in one cycle, the lower-numbered port is served and the higher one is stalled, with no other effect.
- R10: When two upstream lanes carry the same address in one cycle, the higher lane gets retry and only the lower lane takes effect. Two lanes with different addresses can both take free entries in the same cycle.
- R11: A flush pulse empties the table and clears every downstream lane at the next clock edge.
- R12: A new declaration of an address that is already in the table puts it back to pending. An upstream store to an address that was never declared creates an entry that already holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Abort or write-back-done pulse: clears all state |
| loc_valid | input | NUM_PORTS | Local request valid, one per port |
| loc_op | input | NUM_PORTS x 2 | Local op: 00 declare, 01 store, 10 release, 11 load |
| loc_addr | input | NUM_PORTS x ADDR_W | Local request address |
| loc_wdata | input | NUM_PORTS x DATA_W | Local store data |
| loc_stall | output | NUM_PORTS | Request not taken this cycle; present it again |
| loc_fwd | output | NUM_PORTS | Load served with forwarded data |
| loc_miss | output | NUM_PORTS | Load must be read from the data cache |
| loc_rdata | output | NUM_PORTS x DATA_W | Forwarded load data (zero when not forwarding) |
| up_valid | input | NUM_PORTS | Upstream event valid, one per lane |
| up_op | input | NUM_PORTS x 2 | Upstream op: 00 declare, 01 store, 10 release |
| up_addr | input | NUM_PORTS x ADDR_W | Upstream event address |
| up_data | input | NUM_PORTS x DATA_W | Upstream store data |
| up_retry | output | NUM_PORTS | Upstream event refused this cycle |
| dn_valid | output | NUM_PORTS | Downstream event valid |
| dn_op | output | NUM_PORTS x 2 | Downstream op code |
| dn_addr | output | NUM_PORTS x ADDR_W | Downstream address |
| dn_data | output | NUM_PORTS x DATA_W | Downstream data |
| dn_retry | input | NUM_PORTS | Successor refuses the event on this lane |

## Verification
Load responses (stall, forward, miss, data) and both retry outputs are combinational. The bench therefore reads them five nanoseconds after it drives the request on the falling edge, in the same cycle. An upstream event changes the table at the rising edge that follows, so the load that checks its effect is driven in the next cycle. Downstream lanes carry one register, so they are read half a cycle after the rising edge that captured the local request. Hold and clear behaviour is read one full cycle after that.

// File: rtl/tsdep_pkg.sv
package tsdep_pkg;

  // Request op codes shared by the local port and both ring links.
  typedef enum logic [1:0] {
    OP_ALLOC   = 2'b00,
    OP_STORE   = 2'b01,
    OP_RELEASE = 2'b10,
    OP_LOAD    = 2'b11
  } tsop_e;

  // Entry life cycle.
  typedef enum logic [1:0] {
    ST_FREE = 2'b00,
    ST_PEND = 2'b01,
    ST_DATA = 2'b10,
    ST_REL  = 2'b11
  } tsst_e;

endpackage

// File: rtl/tsdep_match.sv
// Associative lookup: lowest occupied entry whose tag equals the key.
module tsdep_match #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 16,
  parameter int IDX_W       = 3
) (
  input  logic [NUM_ENTRIES-1:0]             occupied,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]                  key,
  output logic                               hit,
  output logic [IDX_W-1:0]                   idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (!hit && occupied[e] && (tags[e] == key)) begin
        hit = 1'b1;
        idx = IDX_W'(e);
      end
    end
  end

endmodule

// File: rtl/tsdep_slot_alloc.sv
// Hands distinct free entries to requesters, lower requester first.
module tsdep_slot_alloc #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_REQ     = 2,
  parameter int IDX_W       = 3
) (
  input  logic [NUM_ENTRIES-1:0]          occupied,
  input  logic [NUM_REQ-1:0]              need,
  output logic [NUM_REQ-1:0]              grant_ok,
  output logic [NUM_REQ-1:0][IDX_W-1:0]   grant_idx
);

  logic [NUM_ENTRIES-1:0] avail;

  always_comb begin
    avail     = ~occupied;
    grant_ok  = '0;
    grant_idx = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (need[r]) begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (!grant_ok[r] && avail[e]) begin
            grant_ok[r]  = 1'b1;
            grant_idx[r] = IDX_W'(e);
          end
        end
        if (grant_ok[r]) avail[grant_idx[r]] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/tsdep_fwd_lane.sv
// One registered downstream lane with hold-on-retry.
module tsdep_fwd_lane #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              hold,
  input  logic              load_en,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  logic valid_d;
  logic pay_en;

  always_comb begin
    pay_en = 1'b0;
    if (flush) begin
      valid_d = 1'b0;
    end else if (out_valid && hold) begin
      valid_d = 1'b1;
    end else begin
      valid_d = load_en;
      pay_en  = load_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (pay_en) begin
      out_op   <= in_op;
      out_addr <= in_addr;
      out_data <= in_data;
    end
  end

endmodule

// File: rtl/tsdep_buffer.sv
module tsdep_buffer
  import tsdep_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic [NUM_PORTS-1:0]              loc_valid,
  input  logic [NUM_PORTS-1:0][1:0]         loc_op,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  loc_addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  loc_wdata,
  output logic [NUM_PORTS-1:0]              loc_stall,
  output logic [NUM_PORTS-1:0]              loc_fwd,
  output logic [NUM_PORTS-1:0]              loc_miss,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  loc_rdata,
  input  logic [NUM_PORTS-1:0]              up_valid,
  input  logic [NUM_PORTS-1:0][1:0]         up_op,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  up_addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  up_data,
  output logic [NUM_PORTS-1:0]              up_retry,
  output logic [NUM_PORTS-1:0]              dn_valid,
  output logic [NUM_PORTS-1:0][1:0]         dn_op,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]  dn_addr,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  dn_data,
  input  logic [NUM_PORTS-1:0]              dn_retry
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  // Entry table
  tsst_e [NUM_ENTRIES-1:0]             st_q, st_d;
  logic  [NUM_ENTRIES-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic  [NUM_ENTRIES-1:0][DATA_W-1:0] val_q, val_d;
  logic  [NUM_ENTRIES-1:0]             ent_we;
  logic  [NUM_ENTRIES-1:0]             occupied;

  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) occupied[e] = (st_q[e] != ST_FREE);
  end

  // Lookups
  logic [NUM_PORTS-1:0]            l_hit, u_hit;
  logic [NUM_PORTS-1:0][IDX_W-1:0] l_idx, u_idx;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_lookup
      tsdep_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_lmatch (
        .occupied (occupied),
        .tags     (tag_q),
        .key      (loc_addr[gp]),
        .hit      (l_hit[gp]),
        .idx      (l_idx[gp])
      );
      tsdep_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_umatch (
        .occupied (occupied),
        .tags     (tag_q),
        .key      (up_addr[gp]),
        .hit      (u_hit[gp]),
        .idx      (u_idx[gp])
      );
    end
  endgenerate

  // Same-address arbitration: lower index wins
  logic [NUM_PORTS-1:0] l_conf, u_conf;

  always_comb begin
    l_conf = '0;
    u_conf = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q < p) begin
          if (loc_valid[p] && loc_valid[q] && (loc_addr[q] == loc_addr[p])) l_conf[p] = 1'b1;
          if (up_valid[p]  && up_valid[q]  && (up_addr[q]  == up_addr[p]))  u_conf[p] = 1'b1;
        end
      end
    end
  end

  // Upstream lanes: slot allocation and retry
  logic [NUM_PORTS-1:0]            u_need, u_acc, g_ok;
  logic [NUM_PORTS-1:0][IDX_W-1:0] g_idx;

  always_comb begin
    for (int l = 0; l < NUM_PORTS; l++) begin
      u_need[l] = up_valid[l] && !u_conf[l] && !u_hit[l] &&
                  ((up_op[l] == OP_ALLOC) || (up_op[l] == OP_STORE));
    end
  end

  tsdep_slot_alloc #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_REQ(NUM_PORTS), .IDX_W(IDX_W)) i_slots (
    .occupied  (occupied),
    .need      (u_need),
    .grant_ok  (g_ok),
    .grant_idx (g_idx)
  );

  always_comb begin
    for (int l = 0; l < NUM_PORTS; l++) begin
      up_retry[l] = up_valid[l] && (u_conf[l] || (u_need[l] && !g_ok[l]));
      u_acc[l]    = up_valid[l] && !up_retry[l];
    end
  end

  // Table next state
  always_comb begin
    st_d   = st_q;
    tag_d  = tag_q;
    val_d  = val_q;
    ent_we = '0;
    if (flush) begin
      for (int e = 0; e < NUM_ENTRIES; e++) st_d[e] = ST_FREE;
    end else begin
      for (int l = 0; l < NUM_PORTS; l++) begin
        if (u_acc[l]) begin
          if (u_hit[l]) begin
            case (up_op[l])
              OP_ALLOC:   st_d[u_idx[l]] = ST_PEND;
              OP_STORE: begin
                st_d[u_idx[l]]   = ST_DATA;
                val_d[u_idx[l]]  = up_data[l];
                ent_we[u_idx[l]] = 1'b1;
              end
              OP_RELEASE: st_d[u_idx[l]] = ST_REL;
              default:    ;
            endcase
          end else if (u_need[l] && g_ok[l]) begin
            st_d[g_idx[l]]   = (up_op[l] == OP_STORE) ? ST_DATA : ST_PEND;
            tag_d[g_idx[l]]  = up_addr[l];
            val_d[g_idx[l]]  = up_data[l];
            ent_we[g_idx[l]] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) st_q[e] <= ST_FREE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (ent_we[e]) begin
        tag_q[e] <= tag_d[e];
        val_q[e] <= val_d[e];
      end
    end
  end

  // Local port responses
  logic [NUM_PORTS-1:0] l_is_load, dn_busy, dn_load;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      l_is_load[p] = (loc_op[p] == OP_LOAD);
      dn_busy[p]   = dn_valid[p] && dn_retry[p];
      loc_stall[p] = loc_valid[p] &&
                     (l_conf[p] ||
                      (l_is_load[p] && l_hit[p] && (st_q[l_idx[p]] == ST_PEND)) ||
                      (!l_is_load[p] && dn_busy[p]));
      loc_fwd[p]   = loc_valid[p] && !l_conf[p] && l_is_load[p] && l_hit[p] &&
                     (st_q[l_idx[p]] == ST_DATA);
      loc_miss[p]  = loc_valid[p] && !l_conf[p] && l_is_load[p] &&
                     (!l_hit[p] || (st_q[l_idx[p]] == ST_REL));
      loc_rdata[p] = loc_fwd[p] ? val_q[l_idx[p]] : '0;
      dn_load[p]   = loc_valid[p] && !l_is_load[p] && !l_conf[p] && !dn_busy[p];
    end
  end

  // Downstream lanes
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_dn
      tsdep_fwd_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .hold      (dn_retry[gp]),
        .load_en   (dn_load[gp]),
        .in_op     (loc_op[gp]),
        .in_addr   (loc_addr[gp]),
        .in_data   (loc_wdata[gp]),
        .out_valid (dn_valid[gp]),
        .out_op    (dn_op[gp]),
        .out_addr  (dn_addr[gp]),
        .out_data  (dn_data[gp])
      );
    end
  endgenerate

endmodule

// File: rtl/tsdep_buffer_chk.sv
module tsdep_buffer_chk #(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 16
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             flush,
  input logic [NUM_PORTS-1:0]             loc_valid,
  input logic [NUM_PORTS-1:0][1:0]        loc_op,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] loc_addr,
  input logic [NUM_PORTS-1:0]             loc_stall,
  input logic [NUM_PORTS-1:0]             loc_fwd,
  input logic [NUM_PORTS-1:0]             loc_miss,
  input logic [NUM_PORTS-1:0]             up_valid,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] up_addr,
  input logic [NUM_PORTS-1:0]             up_retry,
  input logic [NUM_PORTS-1:0]             dn_valid,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] dn_addr,
  input logic [NUM_PORTS-1:0]             dn_retry
);

  // R11: flush leaves no downstream lane valid
  p_flush_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (dn_valid == '0));

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      // R3: load outcomes exclusive
      p_resp_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_stall[gp], loc_fwd[gp], loc_miss[gp]}));

      // R7: accepted non-load request appears downstream next cycle
      p_fwd_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && loc_valid[gp] && (loc_op[gp] != 2'b11) && !loc_stall[gp])
        |=> (dn_valid[gp] && (dn_addr[gp] == $past(loc_addr[gp]))));

      // R8: retried lane holds its event
      p_lane_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid[gp] && dn_retry[gp] && !flush)
        |=> (dn_valid[gp] && $stable(dn_addr[gp])));

      if (gp > 0) begin : g_hi
        // R9: higher local port loses a same-address race
        p_loc_conf_r9: assert property (@(posedge clk) disable iff (!rst_n)
          (loc_valid[gp] && loc_valid[0] && (loc_addr[gp] == loc_addr[0]))
          |-> loc_stall[gp]);

        // R10: higher upstream lane loses a same-address race
        p_up_conf_r10: assert property (@(posedge clk) disable iff (!rst_n)
          (up_valid[gp] && up_valid[0] && (up_addr[gp] == up_addr[0]))
          |-> up_retry[gp]);
      end
    end
  endgenerate

endmodule

bind tsdep_buffer tsdep_buffer_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) i_tsdep_buffer_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .loc_valid (loc_valid),
  .loc_op    (loc_op),
  .loc_addr  (loc_addr),
  .loc_stall (loc_stall),
  .loc_fwd   (loc_fwd),
  .loc_miss  (loc_miss),
  .up_valid  (up_valid),
  .up_addr   (up_addr),
  .up_retry  (up_retry),
  .dn_valid  (dn_valid),
  .dn_addr   (dn_addr),
  .dn_retry  (dn_retry)
);

// File: tb/test_tsdep_buffer.sv
`timescale 1ns/1ps
module test_tsdep_buffer;

  localparam int NP = 2;
  localparam int AW = 16;
  localparam int DW = 32;

  logic                 clk;
  logic                 rst_n;
  logic                 flush;
  logic [NP-1:0]        loc_valid;
  logic [NP-1:0][1:0]   loc_op;
  logic [NP-1:0][AW-1:0] loc_addr;
  logic [NP-1:0][DW-1:0] loc_wdata;
  logic [NP-1:0]        loc_stall, loc_fwd, loc_miss;
  logic [NP-1:0][DW-1:0] loc_rdata;
  logic [NP-1:0]        up_valid;
  logic [NP-1:0][1:0]   up_op;
  logic [NP-1:0][AW-1:0] up_addr;
  logic [NP-1:0][DW-1:0] up_data;
  logic [NP-1:0]        up_retry;
  logic [NP-1:0]        dn_valid;
  logic [NP-1:0][1:0]   dn_op;
  logic [NP-1:0][AW-1:0] dn_addr;
  logic [NP-1:0][DW-1:0] dn_data;
  logic [NP-1:0]        dn_retry;

  tsdep_buffer #(.NUM_ENTRIES(8), .NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) i_tsdep_buffer (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .loc_valid(loc_valid), .loc_op(loc_op), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_stall(loc_stall), .loc_fwd(loc_fwd), .loc_miss(loc_miss), .loc_rdata(loc_rdata),
    .up_valid(up_valid), .up_op(up_op), .up_addr(up_addr), .up_data(up_data),
    .up_retry(up_retry),
    .dn_valid(dn_valid), .dn_op(dn_op), .dn_addr(dn_addr), .dn_data(dn_data),
    .dn_retry(dn_retry)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Row: one upstream event on lane 0, then a load on port 0.
  // resp = {stall, fwd, miss}
  typedef struct packed {
    logic [7:0]  req;
    logic        uv;
    logic [1:0]  uop;
    logic [15:0] uaddr;
    logic [31:0] udata;
    logic [15:0] laddr;
    logic [2:0]  resp;
    logic [31:0] rdata;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd2,  1'b1, 2'b00, 16'h0010, 32'h0,        16'h0010, 3'b100, 32'h0},        // R2 declare -> stall
    '{8'd3,  1'b1, 2'b01, 16'h0010, 32'hAAAA5555, 16'h0010, 3'b010, 32'hAAAA5555}, // R3 store -> forward
    '{8'd2,  1'b1, 2'b00, 16'h0020, 32'h0,        16'h0020, 3'b100, 32'h0},        // R2
    '{8'd4,  1'b1, 2'b10, 16'h0020, 32'h0,        16'h0020, 3'b001, 32'h0},        // R4 release -> miss
    '{8'd5,  1'b0, 2'b00, 16'h0000, 32'h0,        16'h0030, 3'b001, 32'h0},        // R5 unknown -> miss
    '{8'd12, 1'b1, 2'b00, 16'h0010, 32'h0,        16'h0010, 3'b100, 32'h0},        // R12 redeclare -> pending
    '{8'd12, 1'b1, 2'b01, 16'h0040, 32'h12345678, 16'h0040, 3'b010, 32'h12345678}, // R12 undeclared store
    '{8'd4,  1'b1, 2'b10, 16'h0050, 32'h0,        16'h0050, 3'b001, 32'h0}         // R4 unknown release
  };

  task automatic idle_inputs();
    loc_valid = '0; loc_op = '0; loc_addr = '0; loc_wdata = '0;
    up_valid = '0; up_op = '0; up_addr = '0; up_data = '0;
    dn_retry = '0; flush = 1'b0;
  endtask

  task automatic up_event(input int lane, input logic [1:0] op, input logic [15:0] a,
                          input logic [31:0] d);
    up_valid[lane] = 1'b1; up_op[lane] = op; up_addr[lane] = a; up_data[lane] = d;
  endtask

  task automatic loc_req(input int port, input logic [1:0] op, input logic [15:0] a,
                         input logic [31:0] d);
    loc_valid[port] = 1'b1; loc_op[port] = op; loc_addr[port] = a; loc_wdata[port] = d;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    loc_req(0, 2'b11, 16'h0010, 0);
    #5;
    chk("R1 load miss after reset", {61'd0, loc_stall[0], loc_fwd[0], loc_miss[0]}, 64'b001);
    chk("R1 no downstream valid", {62'd0, dn_valid}, 64'd0);
    chk("R1 no upstream retry", {62'd0, up_retry}, 64'd0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      idle_inputs();
      if (VECS[i].uv) up_event(0, VECS[i].uop, VECS[i].uaddr, VECS[i].udata);
      @(negedge clk);
      idle_inputs();
      loc_req(0, 2'b11, VECS[i].laddr, 0);
      #5;
      chk($sformatf("R%0d row %0d response", VECS[i].req, i),
          {61'd0, loc_stall[0], loc_fwd[0], loc_miss[0]}, {61'd0, VECS[i].resp});
      chk($sformatf("R%0d row %0d data", VECS[i].req, i), {32'd0, loc_rdata[0]},
          {32'd0, VECS[i].rdata});
    end

    // R6: fill to 8 entries (3 in use), then overflow
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      idle_inputs();
      up_event(0, 2'b00, 16'h0100 + 16'(k), 0);
    end
    @(negedge clk);
    idle_inputs();
    up_event(0, 2'b00, 16'h0200, 0);
    #5;
    chk("R6 retry when full", {62'd0, up_retry}, 64'b01);
    @(negedge clk);
    idle_inputs();
    loc_req(0, 2'b11, 16'h0200, 0);
    #5;
    chk("R6 refused declare not recorded", {61'd0, loc_stall[0], loc_fwd[0], loc_miss[0]}, 64'b001);
    @(negedge clk);
    idle_inputs();
    up_event(0, 2'b01, 16'h0020, 32'h00000077);
    #5;
    chk("R6 hit accepted when full", {62'd0, up_retry}, 64'd0);
    @(negedge clk);
    idle_inputs();
    loc_req(1, 2'b11, 16'h0020, 0);
    #5;
    chk("R6 hit store forwarded", {32'd0, loc_rdata[1]}, 64'h77);

    // R11: flush
    @(negedge clk);
    idle_inputs();
    flush = 1'b1;
    @(negedge clk);
    idle_inputs();
    loc_req(0, 2'b11, 16'h0010, 0);
    loc_req(1, 2'b11, 16'h0104, 0);
    #5;
    chk("R11 table empty after flush", {62'd0, loc_miss}, 64'b11);

    // R10: upstream same-address race, then two distinct allocations
    @(negedge clk);
    idle_inputs();
    up_event(0, 2'b00, 16'h0070, 0);
    up_event(1, 2'b00, 16'h0070, 0);
    #5;
    chk("R10 upper lane retried", {62'd0, up_retry}, 64'b10);
    @(negedge clk);
    idle_inputs();
    up_event(0, 2'b00, 16'h0080, 0);
    up_event(1, 2'b00, 16'h0090, 0);
    #5;
    chk("R10 two free slots granted", {62'd0, up_retry}, 64'd0);
    @(negedge clk);
    idle_inputs();
    loc_req(0, 2'b11, 16'h0080, 0);
    loc_req(1, 2'b11, 16'h0090, 0);
    #5;
    chk("R10 both entries pending", {62'd0, loc_stall}, 64'b11);

    // R7: local events go downstream one cycle later
    @(negedge clk);
    idle_inputs();
    loc_req(0, 2'b01, 16'h0300, 32'hCAFE0001);
    loc_req(1, 2'b10, 16'h0301, 32'h0);
    @(negedge clk);
    idle_inputs();
    chk("R7 both lanes valid", {62'd0, dn_valid}, 64'b11);
    chk("R7 lane0 address", {48'd0, dn_addr[0]}, 64'h0300);
    chk("R7 lane0 data", {32'd0, dn_data[0]}, 64'hCAFE0001);
    chk("R7 lane1 op", {62'd0, dn_op[1]}, 64'b10);
    loc_req(0, 2'b11, 16'h0300, 0);
    @(negedge clk);
    idle_inputs();
    chk("R7 load not forwarded", {62'd0, dn_valid}, 64'd0);

    // R9: local same-address race
    loc_req(0, 2'b01, 16'h0400, 32'h1);
    loc_req(1, 2'b01, 16'h0400, 32'h2);
    #5;
    chk("R9 upper port stalled", {62'd0, loc_stall}, 64'b10);
    @(negedge clk);
    idle_inputs();
    chk("R9 only lower port sent", {62'd0, dn_valid}, 64'b01);

    // R8: retry holds the lane and stalls the port
    loc_req(0, 2'b01, 16'h0500, 32'h55);
    @(negedge clk);
    idle_inputs();
    dn_retry[0] = 1'b1;
    loc_req(0, 2'b00, 16'h0501, 0);
    #5;
    chk("R8 port stalled under retry", {63'd0, loc_stall[0]}, 64'd1);
    @(negedge clk);
    chk("R8 lane held valid", {63'd0, dn_valid[0]}, 64'd1);
    chk("R8 lane held address", {48'd0, dn_addr[0]}, 64'h0500);
    idle_inputs();
    @(negedge clk);
    chk("R8 lane drains after retry", {63'd0, dn_valid[0]}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule